// File: doc/BRIEF.md
# DMA Access Arbiter for a Tightly Coupled Data RAM

This block lets an external DMA master reach a data RAM that a CPU also uses. The DMA side presents a byte address, write data, a transfer size, an active-low request, a read/write select, a port enable and a wait (stall) request. The RAM side receives word addresses, a chip enable and per-byte write enables. The CPU is modelled as a plain RAM-style request interface plus a stall output.

A build-time parameter selects one of two variants. With one RAM port, the DMA master first raises its wait request. The block then stalls the CPU and raises ready. From that point the DMA transfer is steered onto the shared port in place of the CPU. With two RAM ports, the CPU keeps the first port to itself. The DMA master drives the second port directly. The wait input is ignored and the CPU is never stalled.

Read data for the DMA master comes from a RAM with one cycle of latency. It is presented on the cycle after the access and is zero on every other cycle.

Top module: `dma_ram_arbiter`

## Requirements
- R1: The RAM word address driven for a DMA access is the DMA byte address with its two low bits dropped (address bits [25:2] of the 26-bit byte address).
- R2: A DMA byte write (size code 00) sets exactly one write-enable bit, the one at index address[1:0]. Enable bit k covers write-data bits [8k+7:8k]. The write data is passed to the RAM unchanged.
- R3: A halfword write (size code 01) enables lanes 1 and 0 (0011) when address[1] is 0 and lanes 3 and 2 (1100) when it is 1. A word write (size code 10) enables all four lanes (1111).
- R4: A write with the reserved size code 11 still asserts the RAM chip enable for that cycle, with all write enables low. RAM contents are left unchanged.
- R5: A DMA read (read/write select 0) drives all write enables low. The full 32-bit RAM word appears on the DMA read-data output in the cycle after the access. DMA read data is zero in every cycle that does not follow a DMA read.
- R6: No DMA access reaches any RAM port while the DMA enable is low or the active-low request is high.
- R7: Single-port variant: the CPU stall output and the DMA ready output are high in the cycle after wait is sampled high, and low in the cycle after wait is sampled low.
- R8: Single-port variant: a DMA transfer drives the RAM port only while ready is high. While ready is low, the RAM port carries the CPU's enable, address, data and byte enables.
- R9: Dual-port variant: wait is ignored, stall and ready stay low, and DMA transfers use the second RAM port while the first port carries the CPU's signals.
- R10: After reset, stall and ready are low and DMA read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_addr | input | 26 | DMA byte address |
| dma_wdata | input | 32 | DMA write data |
| dma_size | input | 2 | Write size: 00 byte, 01 halfword, 10 word, 11 reserved |
| dma_req_n | input | 1 | Active-low DMA transfer request |
| dma_wr | input | 1 | 1 write, 0 read |
| dma_en | input | 1 | DMA port enable |
| dma_wait | input | 1 | Stall request (single-port variant only) |
| dma_rdata | output | 32 | DMA read data, one cycle after the access |
| dma_ready | output | 1 | CPU is stalled; DMA may transfer |
| cpu_en | input | 1 | CPU RAM chip enable |
| cpu_addr | input | 24 | CPU RAM word address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_be | input | 4 | CPU byte write enables |
| cpu_stall | output | 1 | Stall to the CPU |
| cpu_rdata | output | 32 | RAM read data towards the CPU |
| ram_addr | output | 24 | First RAM port word address |
| ram_en | output | 1 | First RAM port chip enable |
| ram_wdata | output | 32 | First RAM port write data |
| ram_be | output | 4 | First RAM port byte write enables |
| ram_rdata | input | 32 | First RAM port read data |
| ram2_addr | output | 24 | Second RAM port word address |
| ram2_en | output | 1 | Second RAM port chip enable |
| ram2_wdata | output | 32 | Second RAM port write data |
| ram2_be | output | 4 | Second RAM port byte write enables |
| ram2_rdata | input | 32 | Second RAM port read data |

## Verification
The assertions assume the RAM returns the addressed word one cycle after an enabled cycle. They also assume a single-port DMA master keeps wait high for the whole of its transfer, because the ready check only looks one cycle after each wait sample. The stimulus changes every input on the falling clock edge. It keeps wait high across each single-port transfer, and its RAM models read and write on the rising edge with one cycle of read latency. Byte-enable and address checks are made on the combinational RAM outputs before the rising edge. Read-data checks are made one falling edge after the access.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } dma_size_e;
endpackage

// File: rtl/dma_lane_dec.sv
module dma_lane_dec
  import dma_arb_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFS_W = 2
) (
  input  logic             wr_i,
  input  dma_size_e        size_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [LANES-1:0] be_o
);
  logic [LANES-1:0] be_c;

  always_comb begin
    be_c = '0;
    for (int i = 0; i < LANES; i++) begin
      unique case (size_i)
        SZ_BYTE: be_c[i] = (OFS_W'(i) == ofs_i);
        SZ_HALF: be_c[i] = (OFS_W'(i >> 1) == (ofs_i >> 1));
        SZ_WORD: be_c[i] = 1'b1;
        default: be_c[i] = 1'b0;
      endcase
    end
    if (!wr_i) be_c = '0;
    be_o = be_c;

    if (wr_i === 1'b1 && size_i == SZ_BYTE)
      a_r2_byte_onehot: assert ($countones(be_c) == 1);
    if (wr_i === 1'b1 && size_i == SZ_HALF)
      a_r3_half_two_lanes: assert ($countones(be_c) == 2);
    if (size_i == SZ_RSVD)
      a_r4_reserved_no_lane: assert (be_c == '0);
    if (wr_i === 1'b0)
      a_r5_read_no_lane: assert (be_c == '0);
  end
endmodule

// File: rtl/dma_stall_ctrl.sv
module dma_stall_ctrl #(
  parameter bit DUAL_PORT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_i,
  output logic stall_o
);
  generate
    if (DUAL_PORT) begin : g_dual
      assign stall_o = 1'b0;
    end else begin : g_single
      logic stall_d, stall_q;

      always_comb stall_d = wait_i;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stall_q <= 1'b0;
        else        stall_q <= stall_d;
      end

      assign stall_o = stall_q;

      a_r7_stall_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
        wait_i |=> stall_o);
      a_r7_release_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_i |=> !stall_o);
    end
  endgenerate
endmodule

// File: rtl/dma_port_mux.sv
module dma_port_mux #(
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic             sel_dma_i,
  input  logic             cpu_en_i,
  input  logic [AW-1:0]    cpu_addr_i,
  input  logic [DW-1:0]    cpu_wdata_i,
  input  logic [LANES-1:0] cpu_be_i,
  input  logic             dma_en_i,
  input  logic [AW-1:0]    dma_addr_i,
  input  logic [DW-1:0]    dma_wdata_i,
  input  logic [LANES-1:0] dma_be_i,
  output logic             en_o,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    wdata_o,
  output logic [LANES-1:0] be_o
);
  always_comb begin
    if (sel_dma_i) begin
      en_o    = dma_en_i;
      addr_o  = dma_addr_i;
      wdata_o = dma_wdata_i;
      be_o    = dma_be_i;
    end else begin
      en_o    = cpu_en_i;
      addr_o  = cpu_addr_i;
      wdata_o = cpu_wdata_i;
      be_o    = cpu_be_i;
    end
  end
endmodule

// File: rtl/dma_ram_arbiter.sv
module dma_ram_arbiter
  import dma_arb_pkg::*;
#(
  parameter bit DUAL_PORT = 1'b0,
  parameter int ADDR_W    = 26,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            dma_addr,
  input  logic [DATA_W-1:0]            dma_wdata,
  input  logic [1:0]                   dma_size,
  input  logic                         dma_req_n,
  input  logic                         dma_wr,
  input  logic                         dma_en,
  input  logic                         dma_wait,
  output logic [DATA_W-1:0]            dma_rdata,
  output logic                         dma_ready,
  input  logic                         cpu_en,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] cpu_addr,
  input  logic [DATA_W-1:0]            cpu_wdata,
  input  logic [DATA_W/8-1:0]          cpu_be,
  output logic                         cpu_stall,
  output logic [DATA_W-1:0]            cpu_rdata,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] ram_addr,
  output logic                         ram_en,
  output logic [DATA_W-1:0]            ram_wdata,
  output logic [DATA_W/8-1:0]          ram_be,
  input  logic [DATA_W-1:0]            ram_rdata,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] ram2_addr,
  output logic                         ram2_en,
  output logic [DATA_W-1:0]            ram2_wdata,
  output logic [DATA_W/8-1:0]          ram2_be,
  input  logic [DATA_W-1:0]            ram2_rdata
);
  localparam int LANES  = DATA_W / 8;
  localparam int OFS_W  = $clog2(LANES);
  localparam int RAM_AW = ADDR_W - OFS_W;

  logic              stall_q;
  logic              req_live;
  logic              go;
  logic [LANES-1:0]  dma_be;
  logic [RAM_AW-1:0] dma_waddr;
  logic              rd_pend_d, rd_pend_q;
  logic [DATA_W-1:0] src_rdata;

  assign req_live  = dma_en & ~dma_req_n;
  assign dma_waddr = dma_addr[ADDR_W-1:OFS_W];

  dma_stall_ctrl #(.DUAL_PORT(DUAL_PORT)) u_stall (
    .clk     (clk),
    .rst_n   (rst_n),
    .wait_i  (dma_wait),
    .stall_o (stall_q)
  );

  dma_lane_dec #(.LANES(LANES), .OFS_W(OFS_W)) u_lanes (
    .wr_i   (dma_wr),
    .size_i (dma_size_e'(dma_size)),
    .ofs_i  (dma_addr[OFS_W-1:0]),
    .be_o   (dma_be)
  );

  assign go        = DUAL_PORT ? req_live : (req_live & stall_q);
  assign dma_ready = stall_q;
  assign cpu_stall = stall_q;
  assign cpu_rdata = ram_rdata;

  generate
    if (DUAL_PORT) begin : g_dual
      assign ram_en     = cpu_en;
      assign ram_addr   = cpu_addr;
      assign ram_wdata  = cpu_wdata;
      assign ram_be     = cpu_be;
      assign ram2_en    = go;
      assign ram2_addr  = dma_waddr;
      assign ram2_wdata = dma_wdata;
      assign ram2_be    = go ? dma_be : '0;

      a_r6_port2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en || dma_req_n) |-> !ram2_en);
    end else begin : g_single
      dma_port_mux #(.AW(RAM_AW), .DW(DATA_W), .LANES(LANES)) u_mux (
        .sel_dma_i   (stall_q),
        .cpu_en_i    (cpu_en),
        .cpu_addr_i  (cpu_addr),
        .cpu_wdata_i (cpu_wdata),
        .cpu_be_i    (cpu_be),
        .dma_en_i    (go),
        .dma_addr_i  (dma_waddr),
        .dma_wdata_i (dma_wdata),
        .dma_be_i    (go ? dma_be : '0),
        .en_o        (ram_en),
        .addr_o      (ram_addr),
        .wdata_o     (ram_wdata),
        .be_o        (ram_be)
      );
      assign ram2_en    = 1'b0;
      assign ram2_addr  = '0;
      assign ram2_wdata = '0;
      assign ram2_be    = '0;

      a_r6_port_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ready && (!dma_en || dma_req_n)) |-> !ram_en);
      a_r8_cpu_owns_port: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_ready |-> (ram_en == cpu_en && ram_addr == cpu_addr));
    end
  endgenerate

  // read-return tracking: RAM answers one cycle after an enabled read
  always_comb rd_pend_d = go & ~dma_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend_q <= 1'b0;
    else        rd_pend_q <= rd_pend_d;
  end

  assign src_rdata = (DUAL_PORT != 1'b0) ? ram2_rdata : ram_rdata;
  assign dma_rdata = rd_pend_q ? src_rdata : '0;

  a_r5_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && !dma_wr) |=> (dma_rdata == '0));
endmodule

// File: tb/dma_ram_arbiter_bench.sv
module dma_ram_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [25:0] dma_addr;
  logic [31:0] dma_wdata;
  logic [1:0]  dma_size;
  logic        dma_req_n, dma_wr, dma_en, dma_wait;
  logic        cpu_en;
  logic [23:0] cpu_addr;
  logic [31:0] cpu_wdata;
  logic [3:0]  cpu_be;

  logic [31:0] s_rdata, s_cpu_rdata, s_ram_wdata, s_ram2_wdata;
  logic        s_ready, s_stall, s_ram_en, s_ram2_en;
  logic [23:0] s_ram_addr, s_ram2_addr;
  logic [3:0]  s_ram_be, s_ram2_be;
  logic [31:0] s_ram_rdata;

  logic [31:0] d_rdata, d_cpu_rdata, d_ram_wdata, d_ram2_wdata;
  logic        d_ready, d_stall, d_ram_en, d_ram2_en;
  logic [23:0] d_ram_addr, d_ram2_addr;
  logic [3:0]  d_ram_be, d_ram2_be;
  logic [31:0] d_ram2_rdata;

  logic [31:0] mem_a [16];
  logic [31:0] mem_b [16];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dma_ram_arbiter #(.DUAL_PORT(1'b0)) u_dma_ram_arbiter (
    .clk(clk), .rst_n(rst_n), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .dma_size(dma_size), .dma_req_n(dma_req_n), .dma_wr(dma_wr), .dma_en(dma_en),
    .dma_wait(dma_wait), .dma_rdata(s_rdata), .dma_ready(s_ready),
    .cpu_en(cpu_en), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_stall(s_stall), .cpu_rdata(s_cpu_rdata),
    .ram_addr(s_ram_addr), .ram_en(s_ram_en), .ram_wdata(s_ram_wdata),
    .ram_be(s_ram_be), .ram_rdata(s_ram_rdata),
    .ram2_addr(s_ram2_addr), .ram2_en(s_ram2_en), .ram2_wdata(s_ram2_wdata),
    .ram2_be(s_ram2_be), .ram2_rdata(32'h0)
  );

  dma_ram_arbiter #(.DUAL_PORT(1'b1)) u_dma_ram_arbiter_dp (
    .clk(clk), .rst_n(rst_n), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .dma_size(dma_size), .dma_req_n(dma_req_n), .dma_wr(dma_wr), .dma_en(dma_en),
    .dma_wait(dma_wait), .dma_rdata(d_rdata), .dma_ready(d_ready),
    .cpu_en(cpu_en), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_stall(d_stall), .cpu_rdata(d_cpu_rdata),
    .ram_addr(d_ram_addr), .ram_en(d_ram_en), .ram_wdata(d_ram_wdata),
    .ram_be(d_ram_be), .ram_rdata(32'h0),
    .ram2_addr(d_ram2_addr), .ram2_en(d_ram2_en), .ram2_wdata(d_ram2_wdata),
    .ram2_be(d_ram2_be), .ram2_rdata(d_ram2_rdata)
  );

  // synchronous RAM models, one cycle read latency
  always @(posedge clk) begin
    if (s_ram_en) begin
      for (int k = 0; k < 4; k++)
        if (s_ram_be[k]) mem_a[s_ram_addr[3:0]][8*k +: 8] <= s_ram_wdata[8*k +: 8];
      s_ram_rdata <= mem_a[s_ram_addr[3:0]];
    end
    if (d_ram2_en) begin
      for (int k = 0; k < 4; k++)
        if (d_ram2_be[k]) mem_b[d_ram2_addr[3:0]][8*k +: 8] <= d_ram2_wdata[8*k +: 8];
      d_ram2_rdata <= mem_b[d_ram2_addr[3:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_dma();
    dma_req_n = 1'b1; dma_en = 1'b0; dma_wr = 1'b0; dma_size = 2'b10;
    dma_addr = '0; dma_wdata = '0;
  endtask

  task automatic dma_go(input logic [25:0] a, input logic wr, input logic [1:0] sz,
                        input logic [31:0] wd);
    dma_addr = a; dma_wr = wr; dma_size = sz; dma_wdata = wd;
    dma_en = 1'b1; dma_req_n = 1'b0;
  endtask

  // {size[1:0], addr[1:0], wr, be[3:0]}
  localparam logic [8:0] VEC [11] = '{
    {2'b00, 2'd0, 1'b1, 4'b0001},
    {2'b00, 2'd1, 1'b1, 4'b0010},
    {2'b00, 2'd2, 1'b1, 4'b0100},
    {2'b00, 2'd3, 1'b1, 4'b1000},
    {2'b01, 2'd0, 1'b1, 4'b0011},
    {2'b01, 2'd2, 1'b1, 4'b1100},
    {2'b01, 2'd3, 1'b1, 4'b1100},
    {2'b10, 2'd1, 1'b1, 4'b1111},
    {2'b11, 2'd0, 1'b1, 4'b0000},
    {2'b10, 2'd0, 1'b0, 4'b0000},
    {2'b00, 2'd3, 1'b0, 4'b0000}
  };

  initial begin
    #(8 * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mem_a[i] = '0; mem_b[i] = '0; end
    s_ram_rdata = '0; d_ram2_rdata = '0;
    rst_n = 1'b0; dma_wait = 1'b0;
    cpu_en = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_be = '0;
    idle_dma();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(s_ready == 1'b0 && s_stall == 1'b0, "R10 ready/stall", {s_ready, s_stall}, 0);
    chk(s_rdata == 0 && d_rdata == 0, "R10 rdata", s_rdata | d_rdata, 0);

    // lane table on the dual-port instance (R1 R2 R3 R4 R5)
    for (int v = 0; v < 11; v++) begin
      logic [25:0] a;
      a = {24'h2AF348 + 24'(v), VEC[v][6:5]};
      @(negedge clk);
      dma_go(a, VEC[v][4], VEC[v][8:7], 32'h0);
      #1;
      chk(d_ram2_be == VEC[v][3:0], "R2/R3/R4/R5 lane enables", {28'h0, d_ram2_be},
          {28'h0, VEC[v][3:0]});
      chk(d_ram2_addr == a[25:2] && d_ram2_en, "R1 word address", {8'h0, d_ram2_addr},
          {8'h0, a[25:2]});
    end
    @(negedge clk); idle_dma();

    // R1 explicit address
    dma_go(26'h2ABCDE4, 1'b0, 2'b10, 32'h0); #1;
    chk(d_ram2_addr == 24'hAAF379, "R1 address 0x2ABCDE4", {8'h0, d_ram2_addr}, 32'hAAF379);

    // R6 enable low / request high
    dma_en = 1'b0; #1;
    chk(!d_ram2_en, "R6 enable low", {31'h0, d_ram2_en}, 0);
    dma_en = 1'b1; dma_req_n = 1'b1; #1;
    chk(!d_ram2_en, "R6 request high", {31'h0, d_ram2_en}, 0);

    // R9 dual: wait ignored, port A is CPU's
    @(negedge clk); idle_dma(); dma_wait = 1'b1;
    cpu_en = 1'b1; cpu_addr = 24'h00_0123; cpu_be = 4'b0101; cpu_wdata = 32'h1234_5678;
    dma_go(26'h0000030, 1'b1, 2'b10, 32'hCAFE_F00D);
    @(negedge clk);
    chk(!d_ready && !d_stall, "R9 no stall", {d_ready, d_stall}, 0);
    chk(d_ram_en && d_ram_addr == 24'h123 && d_ram_be == 4'b0101, "R9 port A cpu",
        {8'h0, d_ram_addr}, 32'h123);
    // word 0xC written to mem_b[12]; byte write into lane 1 of the same word
    dma_go(26'h0000031, 1'b1, 2'b00, 32'h0000_5500);
    @(negedge clk);
    dma_go(26'h0000030, 1'b1, 2'b11, 32'hFFFF_FFFF);  // reserved: no change (R4)
    @(negedge clk);
    dma_go(26'h0000030, 1'b0, 2'b10, 32'h0);
    @(negedge clk);
    idle_dma();
    #1;
    chk(d_rdata == 32'hCAFE_550D, "R5/R2/R4 dual read-back", d_rdata, 32'hCAFE_550D);
    @(negedge clk);
    chk(d_rdata == 0, "R5 rdata zero when idle", d_rdata, 0);

    // single-port variant
    dma_wait = 1'b0; cpu_en = 1'b1; cpu_addr = 24'h5; cpu_be = 4'b0000;
    @(negedge clk);
    dma_go(26'h0000014, 1'b1, 2'b10, 32'hDEAD_BEEF); #1;
    chk(s_ram_en && s_ram_addr == 24'h5 && s_ram_be == 4'b0000, "R8 cpu owns port",
        {8'h0, s_ram_addr}, 32'h5);
    chk(!s_ready, "R8 no ready without wait", {31'h0, s_ready}, 0);
    dma_wait = 1'b1; #1;
    chk(!s_ready && !s_stall, "R7 not yet stalled", {s_ready, s_stall}, 0);
    @(negedge clk);
    chk(s_ready && s_stall, "R7 stalled after wait", {s_ready, s_stall}, 32'h3);
    chk(s_ram_en && s_ram_addr == 24'h5 && s_ram_be == 4'hF, "R8 dma drives port",
        {8'h0, s_ram_addr, s_ram_be}, {8'h0, 24'h5, 4'hF});
    @(negedge clk);
    dma_go(26'h0000016, 1'b1, 2'b01, 32'h7777_0000);
    @(negedge clk);
    dma_go(26'h0000014, 1'b0, 2'b10, 32'h0);
    @(negedge clk);
    idle_dma(); #1;
    chk(s_rdata == 32'h7777_BEEF, "R8/R3 single read-back", s_rdata, 32'h7777_BEEF);
    chk(!s_ram_en, "R6 single idle while stalled", {31'h0, s_ram_en}, 0);
    dma_wait = 1'b0;
    @(negedge clk);
    chk(!s_ready && !s_stall, "R7 release", {s_ready, s_stall}, 0);
    chk(s_ram_en == cpu_en && s_ram_addr == cpu_addr, "R8 cpu back", {8'h0, s_ram_addr},
        {8'h0, cpu_addr});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule